// File: doc/BRIEF.md
# Pack Presence and Power-Mode Sequencer

This block is the mode controller at the top of a battery-pack monitor. It holds the pack in one of four modes: Normal, Sleep, Battery-Removed and Shutdown. It also emits the single-cycle strobe that starts each round of measurement and computation. Between strobes the rest of the monitor idles at reduced power.

In Normal and Battery-Removed the strobe comes once per second, where one second is `SEC_CLKS` clock cycles. In Sleep the strobe period is a whole number of seconds taken from an input setting. Sleep is left when a fault is flagged, or when the current comparator requests a wake and wake is enabled. The block samples an active-low presence pin on strobe cycles only. It filters that pin by two matching consecutive samples. A filtered high level drops the pack into Battery-Removed, and in that mode all three FET enables (charge, discharge, zero-volt charge) are off. A configuration bit can mark the pack as non-removable, and the pin is then ignored. A shutdown command stops all activity until the next reset.

Top module: `pack_mode_ctrl`

## Requirements
- R1: While reset is asserted and just after release, the mode is Battery-Removed (code 2), the strobe is low, and all three FET enables are low.
- R2: In Normal mode the strobe is a one-cycle pulse that repeats exactly every `SEC_CLKS` clock cycles.
- R3: In Sleep mode, once started, consecutive strobes are `N * SEC_CLKS` cycles apart. N is the sleep interval input, and a value of 0 counts as 1.
- R4: In Sleep, an asserted fault input, or an asserted wake request while wake is enabled, moves the mode to Normal (code 0) on the next clock edge. A wake request while wake is disabled leaves the mode in Sleep (code 1).
- R5: The presence input is sampled only in cycles where the strobe is high. The filtered level changes only after two consecutive samples agree. When a filtered low is seen in Battery-Removed, the mode becomes Normal.
- R6: When the filtered presence level is high, Normal or Sleep becomes Battery-Removed (code 2) and all three FET enables go low. In Normal and Sleep all three enables are high.
- R7: With the non-removable bit set, the presence input has no effect: Battery-Removed moves to Normal on the next edge, and a high presence level never causes removal.
- R8: A shutdown command moves any other mode to Shutdown (code 3) on the next edge. In Shutdown no strobe is issued, all FET enables are low, and only reset leaves the mode.
- R9: Priority: shutdown wins over removal, and removal wins over sleep and wake. A sleep command in Normal is ignored while the fault input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pres_n_i | input | 1 | Pack presence, low means inserted |
| no_removal_i | input | 1 | Non-removable pack configuration |
| wake_en_i | input | 1 | Enables the current-detect wake |
| wake_i | input | 1 | Wake request from current comparator |
| fault_i | input | 1 | Fault flag |
| sleep_cmd_i | input | 1 | Request to enter Sleep |
| shutdown_cmd_i | input | 1 | Request to enter Shutdown |
| sleep_ivl_i | input | IVL_W | Sleep strobe interval in seconds |
| mode_o | output | 2 | Mode: 0 Normal, 1 Sleep, 2 Removed, 3 Shutdown |
| strobe_o | output | 1 | Measure/compute strobe |
| chg_en_o | output | 1 | Charge FET enable |
| dsg_en_o | output | 1 | Discharge FET enable |
| zvc_en_o | output | 1 | Zero-volt-charge FET enable |

## Verification
The bench sends a presence glitch that lasts exactly one strobe. A filter that trusted a single sample would drop the FETs on that glitch. It also sends a glitch that falls between strobes, which a design sampling every cycle would react to. Sleep periods are measured both for a multi-second setting and for the zero setting, so a counter that is off by one second, or that stalls on 0, shows up as a wrong gap. Two more checks cover wake gating and Shutdown: a wake request with wake disabled must not bring back Normal, and Shutdown must stay silent for several seconds while fault, wake and presence activity continue.

// File: rtl/pack_mode_pkg.sv
package pack_mode_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_SLEEP    = 2'd1,
        MODE_REMOVED  = 2'd2,
        MODE_SHUTDOWN = 2'd3
    } pm_mode_e;
endpackage

// File: rtl/pm_sec_timer.sv
module pm_sec_timer #(
    parameter int SEC_CLKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (SEC_CLKS > 1) ? $clog2(SEC_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SEC_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d  = '0;
            tick_o = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0)) else $error("timer ran while idle"); // R8
endmodule

// File: rtl/pm_pres_filter.sv
module pm_pres_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic pres_n_i,
    output logic removed_o
);
    typedef struct packed {
        logic last;
        logic stable;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (sample_i) begin
            f_d.last = pres_n_i;
            if (pres_n_i == f_q.last) f_d.stable = pres_n_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{last: 1'b1, stable: 1'b1};
        else        f_q <= f_d;
    end

    assign removed_o = f_q.stable;

    AST_PRES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(f_q.stable)) else $error("presence moved off strobe"); // R5
    AST_PRES_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && pres_n_i != f_q.last) |=> $stable(f_q.stable)) else $error("single sample accepted"); // R5
endmodule

// File: rtl/pack_mode_ctrl.sv
module pack_mode_ctrl
    import pack_mode_pkg::*;
#(
    parameter int SEC_CLKS = 32768,
    parameter int IVL_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pres_n_i,
    input  logic             no_removal_i,
    input  logic             wake_en_i,
    input  logic             wake_i,
    input  logic             fault_i,
    input  logic             sleep_cmd_i,
    input  logic             shutdown_cmd_i,
    input  logic [IVL_W-1:0] sleep_ivl_i,
    output logic [1:0]       mode_o,
    output logic             strobe_o,
    output logic             chg_en_o,
    output logic             dsg_en_o,
    output logic             zvc_en_o
);
    typedef struct packed {
        pm_mode_e         mode;
        logic             strobe;
        logic             fet_on;
        logic [IVL_W-1:0] ivl_cnt;
    } seq_t;

    seq_t r_d, r_q;
    logic sec_tick;
    logic pres_high;
    logic removal_seen;
    logic wake_hit;
    logic sleep_fire;
    logic [IVL_W-1:0] ivl_last;

    pm_sec_timer #(.SEC_CLKS(SEC_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.mode != MODE_SHUTDOWN),
        .tick_o (sec_tick)
    );

    pm_pres_filter u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (r_q.strobe),
        .pres_n_i  (pres_n_i),
        .removed_o (pres_high)
    );

    always_comb begin
        r_d          = r_q;
        removal_seen = pres_high && !no_removal_i;
        wake_hit     = fault_i || (wake_en_i && wake_i);
        ivl_last     = (sleep_ivl_i == '0) ? '0 : sleep_ivl_i - 1'b1;
        sleep_fire   = 1'b0;

        if (r_q.mode == MODE_SLEEP) begin
            if (sec_tick) begin
                if (r_q.ivl_cnt >= ivl_last) begin
                    r_d.ivl_cnt = '0;
                    sleep_fire  = 1'b1;
                end else begin
                    r_d.ivl_cnt = r_q.ivl_cnt + 1'b1;
                end
            end
        end else begin
            r_d.ivl_cnt = '0;
        end

        case (r_q.mode)
            MODE_NORMAL: begin
                if (shutdown_cmd_i)              r_d.mode = MODE_SHUTDOWN;
                else if (removal_seen)           r_d.mode = MODE_REMOVED;
                else if (sleep_cmd_i && !fault_i) r_d.mode = MODE_SLEEP;
            end
            MODE_SLEEP: begin
                if (shutdown_cmd_i)    r_d.mode = MODE_SHUTDOWN;
                else if (removal_seen) r_d.mode = MODE_REMOVED;
                else if (wake_hit)     r_d.mode = MODE_NORMAL;
            end
            MODE_REMOVED: begin
                if (shutdown_cmd_i)                     r_d.mode = MODE_SHUTDOWN;
                else if (no_removal_i || !pres_high)    r_d.mode = MODE_NORMAL;
            end
            default: r_d.mode = MODE_SHUTDOWN;
        endcase

        r_d.strobe = (r_d.mode != MODE_SHUTDOWN) &&
                     ((r_q.mode == MODE_SLEEP) ? sleep_fire : sec_tick);
        r_d.fet_on = (r_d.mode == MODE_NORMAL) || (r_d.mode == MODE_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mode: MODE_REMOVED, strobe: 1'b0, fet_on: 1'b0, ivl_cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o   = r_q.mode;
    assign strobe_o = r_q.strobe;
    assign chg_en_o = r_q.fet_on;
    assign dsg_en_o = r_q.fet_on;
    assign zvc_en_o = r_q.fet_on;

    AST_SHDN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |=> (mode_o == 2'd3)) else $error("left shutdown"); // R8
    AST_SHDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3) |-> !strobe_o) else $error("strobe in shutdown"); // R8
    AST_FET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o[1]) |-> !(chg_en_o || dsg_en_o || zvc_en_o)) else $error("fet on while off mode"); // R6
    AST_NONREM_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (no_removal_i && mode_o != 2'd2) |=> (mode_o != 2'd2)) else $error("removal while non-removable"); // R7
    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && !fault_i && !(wake_en_i && wake_i)) |=> (mode_o != 2'd0)) else $error("ungated wake"); // R4
    AST_SHDN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_cmd_i) |=> (mode_o == 2'd3)) else $error("shutdown not taken"); // R9
endmodule

// File: tb/pack_mode_ctrl_test.sv
module pack_mode_ctrl_test;
    localparam int CLK_P = 10;
    localparam int SEC   = 8;
    localparam int IVLW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pres_n = 1'b0, no_rem = 1'b0, wake_en = 1'b0, wake = 1'b0;
    logic fault = 1'b0, sleep_cmd = 1'b0, shdn_cmd = 1'b0;
    logic [IVLW-1:0] ivl = '0;
    logic [1:0] mode;
    logic strobe, chg, dsg, zvc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pack_mode_ctrl #(.SEC_CLKS(SEC), .IVL_W(IVLW)) uut (
        .clk(clk), .rst_n(rst_n), .pres_n_i(pres_n), .no_removal_i(no_rem),
        .wake_en_i(wake_en), .wake_i(wake), .fault_i(fault),
        .sleep_cmd_i(sleep_cmd), .shutdown_cmd_i(shdn_cmd), .sleep_ivl_i(ivl),
        .mode_o(mode), .strobe_o(strobe), .chg_en_o(chg), .dsg_en_o(dsg), .zvc_en_o(zvc)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mode(input string req, input int exp);
        check(mode == exp, req, mode, exp);
    endtask

    task automatic chk_fets(input string req, input int exp);
        int v;
        v = {chg, dsg, zvc};
        check(v == exp, req, v, exp);
    endtask

    task automatic wait_strobe();
        @(negedge clk);
        while (!strobe) @(negedge clk);
    endtask

    task automatic gap(output int g);
        wait_strobe();
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!strobe);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_mode("R1 mode in reset", 2);
        chk_fets("R1 fets in reset", 0);
        check(strobe == 1'b0, "R1 strobe in reset", strobe, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_presence_entry();
        wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R5 one low sample keeps removed", 2);
        wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R5 two low samples give normal", 0);
        chk_fets("R6 fets on in normal", 7);
    endtask

    task automatic t_normal_rate();
        int g;
        gap(g);
        check(g == SEC, "R2 normal strobe period", g, SEC);
        gap(g);
        check(g == SEC, "R2 normal strobe period again", g, SEC);
    endtask

    task automatic t_glitch_and_removal();
        wait_strobe();
        @(negedge clk);
        pres_n = 1'b1;
        repeat (SEC - 3) @(negedge clk);
        pres_n = 1'b0;
        wait_strobe();
        pres_n = 1'b1;
        @(negedge clk);
        pres_n = 1'b0;
        wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R5 glitches ignored", 0);
        chk_fets("R5 fets kept through glitches", 7);
        pres_n = 1'b1;
        wait_strobe();
        wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R6 removal mode", 2);
        chk_fets("R6 fets off on removal", 0);
        pres_n = 1'b0;
        wait_strobe();
        wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R5 reinsertion gives normal", 0);
    endtask

    task automatic t_sleep_and_wake();
        int g;
        ivl = 4'd3;
        pulse(sleep_cmd);
        chk_mode("R4 in sleep", 1);
        chk_fets("R6 fets on in sleep", 7);
        wait_strobe();
        gap(g);
        check(g == 3 * SEC, "R3 sleep interval three", g, 3 * SEC);
        wake = 1'b1;
        repeat (3) @(negedge clk);
        chk_mode("R4 wake disabled ignored", 1);
        wake_en = 1'b1;
        @(negedge clk);
        chk_mode("R4 enabled wake exits sleep", 0);
        wake = 1'b0;
        wake_en = 1'b0;
        ivl = '0;
        pulse(sleep_cmd);
        chk_mode("R3 in sleep ivl zero", 1);
        wait_strobe();
        gap(g);
        check(g == SEC, "R3 sleep interval zero as one", g, SEC);
        fault = 1'b1;
        @(negedge clk);
        chk_mode("R4 fault exits sleep", 0);
        pulse(sleep_cmd);
        repeat (2) @(negedge clk);
        chk_mode("R9 sleep blocked by fault", 0);
        fault = 1'b0;
    endtask

    task automatic t_shutdown();
        int cnt;
        sleep_cmd = 1'b1;
        shdn_cmd = 1'b1;
        @(negedge clk);
        sleep_cmd = 1'b0;
        shdn_cmd = 1'b0;
        chk_mode("R9 shutdown beats sleep", 3);
        chk_fets("R8 fets off in shutdown", 0);
        cnt = 0;
        fault = 1'b1;
        wake = 1'b1;
        wake_en = 1'b1;
        pres_n = 1'b1;
        for (int i = 0; i < 4 * SEC; i++) begin
            @(negedge clk);
            if (strobe) cnt++;
            if (i == SEC) pres_n = 1'b0;
        end
        check(cnt == 0, "R8 no strobes in shutdown", cnt, 0);
        chk_mode("R8 shutdown sticky", 3);
        fault = 1'b0;
        wake = 1'b0;
        wake_en = 1'b0;
    endtask

    task automatic t_nonremovable();
        no_rem = 1'b1;
        pres_n = 1'b1;
        do_reset();
        repeat (2) @(negedge clk);
        chk_mode("R7 non-removable enters normal", 0);
        chk_fets("R7 fets on with pin high", 7);
        repeat (3) wait_strobe();
        repeat (2) @(negedge clk);
        chk_mode("R7 pin high ignored", 0);
        no_rem = 1'b0;
        pres_n = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_presence_entry();
        t_normal_rate();
        t_glitch_and_removal();
        t_sleep_and_wake();
        t_shutdown();
        t_nonremovable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule